// File: doc/BRIEF.md
# Serial Register Bank with Frame-Synchronised Commit

This block is a three-wire write-only slave (load line, serial clock, serial data) that fills a bank of 6-bit control registers. A frame opens when the load line goes low. An 8-bit address follows, then one or more 6-bit data words. Each complete word lands in the addressed register, and the address then steps up by one for the next word. All wires are sampled in the master-clock domain through synchronisers and edge detectors.

Each register sits in one of two groups, chosen by the `SL_MASK` parameter. A load-group register shows its new value when the load line rises. A sync-group register is held in a shadow copy after the load line rises. It moves to the active set on the first active horizontal-sync edge that follows the next active vertical-sync edge. Register 0 holds the hold bit and the two sync polarity bits. Register 1 sets how many extra horizontal edges delay the commit. Both of these registers must be in the load group.

The serial pins carry no valid/ready handshake. The host sets the pace, and the slave never pushes back.

Top module: `ser_reg_bank`

## Requirements
- R1: After reset, every active register reads zero.
- R2: Serial data is taken on rising serial-clock edges while the load line is low. The first 8 bits form the address, least significant bit first. The next 6 bits form the data word, least significant bit first.
- R3: A load-group register keeps its old value while the load line is low. It shows the written word once the load line rises.
- R4: While the load line stays low, each further complete 6-bit word goes to the next address up (burst write).
- R5: Bits left over when the load line rises are discarded. This covers two trailing dummy bits and any partial word.
- R6: A sync-group write does not appear when the load line rises. It appears at the first active horizontal edge after the next active vertical edge.
- R7: Register 1 holds a value N. The sync-group commit then happens at the (N+1)-th active horizontal edge after the vertical edge.
- R8: While register 0 bit 0 (hold) is 1, sync-group registers do not change. Writes still pending are applied at a commit point reached after hold is cleared.
- R9: Register 0 bit 1 sets the vertical polarity and bit 2 sets the horizontal polarity. A 0 makes the falling edge active and a 1 makes the rising edge active.
- R10: A word sent to an address at or above `NREG` has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_load | input | 1 | Frame enable, active low; its rising edge commits the load group |
| ser_clk | input | 1 | Serial clock; data taken on rising edges |
| ser_data | input | 1 | Serial data |
| vsync | input | 1 | Vertical sync, polarity from register 0 bit 1 |
| hsync | input | 1 | Horizontal sync, polarity from register 0 bit 2 |
| regs_o | output | NREG*6 | Active registers, register i at bits [6i+5:6i] |

## Verification
A load-line rise can land in the same master cycle as the horizontal edge that commits an earlier sync-group frame. The bench arms a sync-group write and passes a vertical edge. It then writes a load-group register in a second frame. It raises the load line and drops the horizontal sync in the same cycle, so both edges reach the synchronisers together. Both the load-group word and the earlier sync-group word must appear, and no other register may change.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 6;
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int CTL_ADDR   = 0;
  localparam int UPD_ADDR   = 1;
  localparam int HOLD_BIT   = 0;
  localparam int VPOL_BIT   = 1;
  localparam int HPOL_BIT   = 2;
  typedef enum logic {ST_IDLE, ST_COUNT} commit_st_t;
endpackage

// File: rtl/sbw_sync.sv
module sbw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/sbw_deser.sv
module sbw_deser
  import sbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_lvl,
  input  logic              load_fall,
  input  logic              sck_rise,
  input  logic              sd,
  output logic              word_valid,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_data
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] dsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      ptr        <= '0;
      dsh        <= '0;
      word_valid <= 1'b0;
      word_addr  <= '0;
      word_data  <= '0;
    end else if (load_fall) begin
      cnt        <= '0;
      ptr        <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (!load_lvl && sck_rise) begin
        if (cnt < CNT_W'(ADDR_W)) begin
          ptr <= {sd, ptr[ADDR_W-1:1]};
          cnt <= cnt + 1'b1;
        end else if (cnt == CNT_W'(FRAME_BITS - 1)) begin
          word_valid <= 1'b1;
          word_addr  <= ptr;
          word_data  <= {sd, dsh[DATA_W-1:1]};
          ptr        <= ptr + 1'b1;
          cnt        <= CNT_W'(ADDR_W);
        end else begin
          dsh <= {sd, dsh[DATA_W-1:1]};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sbw_commit.sv
module sbw_commit
  import sbw_pkg::*;
#(
  parameter int              NREG    = 16,
  parameter logic [NREG-1:0] SL_MASK = 16'h000F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_rise,
  input  logic                   vs_rise,
  input  logic                   vs_fall,
  input  logic                   hs_rise,
  input  logic                   hs_fall,
  input  logic                   word_valid,
  input  logic [ADDR_W-1:0]      word_addr,
  input  logic [DATA_W-1:0]      word_data,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   hs_act,
  output logic                   hold
);
  logic [NREG-1:0][DATA_W-1:0] shadow, active;
  logic [NREG-1:0]             dirty, ready;
  commit_st_t                  st;
  logic [DATA_W-1:0]           hs_cnt;
  logic                        vs_act, commit_now;
  logic [DATA_W-1:0]           ctl, upd;

  assign ctl        = active[CTL_ADDR];
  assign upd        = active[UPD_ADDR];
  assign hold       = ctl[HOLD_BIT];
  assign vs_act     = ctl[VPOL_BIT] ? vs_rise : vs_fall;
  assign hs_act     = ctl[HPOL_BIT] ? hs_rise : hs_fall;
  assign commit_now = (st == ST_COUNT) && hs_act && (hs_cnt == upd) && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
      dirty  <= '0;
      ready  <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (word_valid && word_addr == ADDR_W'(i)) begin
          shadow[i] <= word_data;
          dirty[i]  <= 1'b1;
        end else if (load_rise) begin
          dirty[i]  <= 1'b0;
        end
        if (SL_MASK[i]) begin
          if (load_rise && dirty[i]) active[i] <= shadow[i];
        end else begin
          if (commit_now && ready[i]) active[i] <= shadow[i];
          if (load_rise && dirty[i])  ready[i]  <= 1'b1;
          else if (commit_now)        ready[i]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      hs_cnt <= '0;
    end else if (vs_act && (|ready)) begin
      st     <= ST_COUNT;
      hs_cnt <= '0;
    end else if (st == ST_COUNT && hs_act) begin
      if (hs_cnt == upd) st <= ST_IDLE;
      else               hs_cnt <= hs_cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*DATA_W +: DATA_W] = active[g];
  end
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
  import sbw_pkg::*;
#(
  parameter int              NREG    = 16,
  parameter logic [NREG-1:0] SL_MASK = 16'h000F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_load,
  input  logic                   ser_clk,
  input  logic                   ser_data,
  input  logic                   vsync,
  input  logic                   hsync,
  output logic [NREG*DATA_W-1:0] regs_o
);
  localparam int NPIN = 5;
  localparam int P_LD = 0, P_CK = 1, P_SD = 2, P_VS = 3, P_HS = 4;

  logic [NPIN-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  assign pin_raw = {hsync, vsync, ser_data, ser_clk, ser_load};

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    sbw_sync #(.STAGES(2)) u_sync (
      .clk (clk), .rst_n(rst_n), .din(pin_raw[p]),
      .lvl (pin_lvl[p]), .rise(pin_rise[p]), .fall(pin_fall[p])
    );
  end

  logic              sl_lvl, sl_rise, word_valid, hs_act, hold;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] word_data;

  assign sl_lvl  = pin_lvl[P_LD];
  assign sl_rise = pin_rise[P_LD];

  sbw_deser u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_lvl  (sl_lvl),
    .load_fall (pin_fall[P_LD]),
    .sck_rise  (pin_rise[P_CK]),
    .sd        (pin_lvl[P_SD]),
    .word_valid(word_valid),
    .word_addr (word_addr),
    .word_data (word_data)
  );

  sbw_commit #(.NREG(NREG), .SL_MASK(SL_MASK)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_rise (sl_rise),
    .vs_rise   (pin_rise[P_VS]),
    .vs_fall   (pin_fall[P_VS]),
    .hs_rise   (pin_rise[P_HS]),
    .hs_fall   (pin_fall[P_HS]),
    .word_valid(word_valid),
    .word_addr (word_addr),
    .word_data (word_data),
    .regs_o    (regs_o),
    .hs_act    (hs_act),
    .hold      (hold)
  );
endmodule

// File: rtl/ser_reg_bank_chk.sv
module ser_reg_bank_chk #(
  parameter int              NREG    = 16,
  parameter logic [NREG-1:0] SL_MASK = 16'h000F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sl_lvl,
  input logic              sl_rise,
  input logic              word_valid,
  input logic              hs_act,
  input logic              hold,
  input logic [NREG*6-1:0] regs_o
);
  assert_word_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(!sl_lvl));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (SL_MASK[i]) begin : g_ld
      assert_load_group_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o[i*6 +: 6]) |-> $past(sl_rise));
    end else begin : g_vs
      assert_sync_group_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o[i*6 +: 6]) |-> $past(hs_act));
      assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> $stable(regs_o[i*6 +: 6]));
    end
  end
endmodule

bind ser_reg_bank ser_reg_bank_chk #(.NREG(NREG), .SL_MASK(SL_MASK)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sl_lvl    (sl_lvl),
  .sl_rise   (sl_rise),
  .word_valid(word_valid),
  .hs_act    (hs_act),
  .hold      (hold),
  .regs_o    (regs_o)
);

// File: tb/ser_reg_bank_tb_top.sv
module ser_reg_bank_tb_top;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_load = 1'b1, ser_clk = 1'b0, ser_data = 1'b0;
  logic vsync = 1'b1, hsync = 1'b1;
  logic [NREG*6-1:0] regs_o;
  logic [5:0] exp_r [NREG];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ser_reg_bank #(.NREG(NREG), .SL_MASK(16'h000F)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_load(ser_load), .ser_clk(ser_clk),
    .ser_data(ser_data), .vsync(vsync), .hsync(hsync), .regs_o(regs_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; tick(3);
    ser_clk = 1'b1; tick(4);
    ser_clk = 1'b0; tick(3);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic open_frame(input logic [7:0] a);
    ser_load = 1'b0; tick(6);
    send_bits(a, 8);
  endtask

  task automatic close_frame();
    ser_load = 1'b1; tick(8);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [5:0] d);
    open_frame(a); send_bits({2'b00, d}, 6); close_frame();
  endtask

  task automatic pulse_vs();
    vsync = ~vsync; tick(6); vsync = ~vsync; tick(6);
  endtask

  task automatic pulse_hs();
    hsync = ~hsync; tick(6); hsync = ~hsync; tick(6);
  endtask

  task automatic check_all(input string req);
    logic ok = 1'b1;
    total++;
    for (int i = 0; i < NREG; i++) begin
      if (ok && regs_o[i*6 +: 6] !== exp_r[i]) begin
        ok = 1'b0; bad++;
        $display("FAIL %s reg%0d actual=%h expected=%h", req, i, regs_o[i*6 +: 6], exp_r[i]);
      end
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) exp_r[i] = '0;
    check_all("R1");
  endtask

  task automatic t_single();
    open_frame(8'h02); send_bits(8'h2D, 6); tick(8);
    check_all("R3");
    close_frame(); exp_r[2] = 6'h2D;
    check_all("R2");
  endtask

  task automatic t_burst();
    open_frame(8'h02); send_bits(8'h0A, 6); send_bits(8'h33, 6); close_frame();
    exp_r[2] = 6'h0A; exp_r[3] = 6'h33;
    check_all("R4");
    open_frame(8'h07); send_bits(8'h01, 6); send_bits(8'h02, 6); send_bits(8'h03, 6); close_frame();
    pulse_vs(); pulse_hs();
    exp_r[7] = 6'h01; exp_r[8] = 6'h02; exp_r[9] = 6'h03;
    check_all("R4");
  endtask

  task automatic t_dummy();
    open_frame(8'h03); send_bits(8'h11, 6); send_bits(8'h03, 2); close_frame();
    exp_r[3] = 6'h11;
    check_all("R5");
    open_frame(8'h02); send_bits(8'h0F, 4); close_frame();
    check_all("R5");
  endtask

  task automatic t_vsync_commit();
    write_reg(8'h04, 6'h15); check_all("R6");
    pulse_hs(); check_all("R6");
    pulse_vs(); check_all("R6");
    pulse_hs(); exp_r[4] = 6'h15; check_all("R6");
  endtask

  task automatic t_delay();
    write_reg(8'h01, 6'h02); exp_r[1] = 6'h02;
    write_reg(8'h05, 6'h2A);
    pulse_vs(); pulse_hs(); check_all("R7");
    pulse_hs(); check_all("R7");
    pulse_hs(); exp_r[5] = 6'h2A; check_all("R7");
    write_reg(8'h01, 6'h00); exp_r[1] = 6'h00;
  endtask

  task automatic t_hold();
    write_reg(8'h00, 6'h01); exp_r[0] = 6'h01;
    write_reg(8'h06, 6'h3C);
    pulse_vs(); pulse_hs(); check_all("R8");
    write_reg(8'h00, 6'h00); exp_r[0] = 6'h00; check_all("R8");
    pulse_vs(); pulse_hs(); exp_r[6] = 6'h3C; check_all("R8");
  endtask

  task automatic t_range();
    write_reg(8'h20, 6'h3F); write_reg(8'h90, 6'h2B);
    pulse_vs(); pulse_hs(); check_all("R10");
    open_frame(8'h0F); send_bits(8'h05, 6); send_bits(8'h06, 6); close_frame();
    pulse_vs(); pulse_hs(); exp_r[15] = 6'h05; check_all("R10");
  endtask

  task automatic t_overlap();
    write_reg(8'h0A, 6'h07);
    pulse_vs();
    open_frame(8'h03); send_bits(8'h25, 6); tick(4);
    ser_load = 1'b1; hsync = 1'b0; tick(8);
    hsync = 1'b1; tick(6);
    exp_r[3] = 6'h25; exp_r[10] = 6'h07;
    check_all("R3");
  endtask

  task automatic t_polarity();
    write_reg(8'h00, 6'h06); exp_r[0] = 6'h06;
    vsync = 1'b0; hsync = 1'b0; tick(6);
    write_reg(8'h0B, 6'h19);
    vsync = 1'b1; tick(6);
    hsync = 1'b1; tick(6);
    exp_r[11] = 6'h19; check_all("R9");
    vsync = 1'b0; hsync = 1'b0; tick(6);
    check_all("R9");
  endtask

  initial begin
    tick(4); rst_n = 1'b1; tick(4);
    t_reset();
    t_single();
    t_burst();
    t_dummy();
    t_vsync_commit();
    t_delay();
    t_hold();
    t_range();
    t_overlap();
    t_polarity();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule